// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a guest access to an I/O port has to leave the guest. A pulse on `start` presents one access. The access is described by the port number, a parameter word and the instruction pointer with the instruction length. The check applies only when the I/O intercept bit of the general intercept vector is set. If that bit is clear, the block answers "no exit" on the next cycle and does not touch memory.

When the I/O intercept bit is set, the block issues one read of a 16-bit window from the permission bitmap in memory. The window starts at the byte that holds the port's bit. Inside that window the block tests a run of consecutive bits whose length is the access size in bytes. Because the run may spill into the second byte, an access that crosses a byte boundary is still caught. On a hit it reports the I/O exit code and the two exit information words.

The controller is a four-state machine:

- **IDLE** waits for `start`. It goes to ISSUE when the intercept bit is set, and to REPORT when it is clear.
- **ISSUE** drives the read request for one cycle and goes to WAIT.
- **WAIT** holds until `rd_valid`, then goes to REPORT.
- **REPORT** pulses `done` and returns to IDLE.

Top module: `iopm_checker_top`

## Requirements
- R1: After reset, `done`, `rd_req` and `exit_hit` are 0, and `exit_code`, `exit_info1` and `exit_info2` are 0.
- R2: When bit 27 of `icept_vec` is clear at `start`, `done` is 1 in the cycle after `start` is sampled, `rd_req` never rises, and `exit_hit` is 0.
- R3: When bit 27 of `icept_vec` is set, exactly one `rd_req` pulse of one cycle is issued, in the cycle after `start`. Its `rd_addr` equals `bitmap_base + (port >> 3)`.
- R4: `rd_data` is little-endian: bits 7:0 are the byte at `rd_addr` and bits 15:8 are the next byte. Bit `port[2:0]` of the window is the first bit tested.
- R5: The access size is `param[6:4]`. The tested run is `((1 << size) - 1) << port[2:0]` over the 16-bit window. `exit_hit` is 1 when any bit of the run is set, including bits in the upper byte.
- R6: A size field of 0 tests no bits, so `exit_hit` is 0 whatever the bitmap holds.
- R7: On a hit, `exit_code` is 0x7B and `exit_info1` is the zero-extended `param` ORed with `port << 16`.
- R8: On a hit, `exit_info2` is `cur_ip + instr_len`, taken at `start`.
- R9: Without a hit, `exit_code`, `exit_info1` and `exit_info2` read 0 when `done` is 1.
- R10: `done` is a single-cycle pulse, one per accepted check. A `start` that arrives while a check is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (accepted in IDLE only) |
| icept_vec | input | 64 | General intercept vector; bit 27 enables I/O checks |
| bitmap_base | input | 64 | Byte address of the permission bitmap |
| port | input | 16 | I/O port number |
| param | input | 32 | Access parameter word; size in bits 6:4 |
| cur_ip | input | 64 | Current instruction pointer |
| instr_len | input | 4 | Instruction length in bytes |
| rd_req | output | 1 | Bitmap read request, one cycle |
| rd_addr | output | 64 | Bitmap read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Little-endian 16-bit bitmap window |
| done | output | 1 | Check complete, one cycle |
| exit_hit | output | 1 | Access must exit |
| exit_code | output | 32 | Exit code (0x7B on hit) |
| exit_info1 | output | 64 | Parameter with port in bits 31:16 |
| exit_info2 | output | 64 | Next instruction pointer |

## Verification
The assertions check the following on every cycle:

- `done` and `rd_req` are one-cycle pulses.
- An accepted check with the intercept bit set requests the right byte address on the following cycle.
- A check with the intercept bit clear completes on the next cycle without a read.
- A miss leaves the exit words at zero, and a hit always carries the I/O exit code.

Whether the tested run is the right one can only be shown by the bench's scenarios against a modelled bitmap. This covers the window byte order, the run length taken from the size field, detection across the byte boundary, and the values of the exit words.

// File: rtl/iopm_pkg.sv
package iopm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } iopm_state_e;

    localparam int unsigned EXIT_IO   = 32'h7B;
    localparam int unsigned EXIT_INTR = 32'h60;
    localparam int unsigned IO_BIT    = EXIT_IO - EXIT_INTR;
endpackage

// File: rtl/iopm_fsm.sv
module iopm_fsm
    import iopm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic icept_on,
    input  logic rd_valid,
    output logic accept,
    output logic capture,
    output logic rd_req,
    output logic done,
    output logic busy
);
    iopm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = icept_on ? ST_ISSUE : ST_REPORT;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (rd_valid) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        rd_req  = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_ISSUE:  rd_req = 1'b1;
            ST_WAIT:   capture = rd_valid;
            ST_REPORT: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/iopm_window_test.sv
module iopm_window_test #(
    parameter int WIN_W  = 16,
    parameter int SIZE_W = 3,
    parameter int OFS_W  = 3
) (
    input  logic [WIN_W-1:0]  window,
    input  logic [SIZE_W-1:0] size,
    input  logic [OFS_W-1:0]  bit_ofs,
    output logic              hit
);
    logic [WIN_W-1:0] run_mask;
    logic [WIN_W-1:0] placed;

    always_comb begin
        run_mask = (WIN_W'(1) << size) - WIN_W'(1);
        placed   = run_mask << bit_ofs;
        hit      = |(window & placed);
    end
endmodule

// File: rtl/iopm_result.sv
module iopm_result #(
    parameter int ADDR_W  = 64,
    parameter int PORT_W  = 16,
    parameter int PARAM_W = 32,
    parameter int IP_W    = 64,
    parameter int LEN_W   = 4,
    parameter int CODE_W  = 32,
    parameter logic [CODE_W-1:0] CODE_IO = 32'h7B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               capture,
    input  logic               win_hit,
    input  logic [ADDR_W-1:0]  bitmap_base,
    input  logic [PORT_W-1:0]  port,
    input  logic [PARAM_W-1:0] param,
    input  logic [IP_W-1:0]    cur_ip,
    input  logic [LEN_W-1:0]   instr_len,
    output logic [PORT_W-1:0]  lat_port,
    output logic [PARAM_W-1:0] lat_param,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               exit_hit,
    output logic [CODE_W-1:0]  exit_code,
    output logic [63:0]        exit_info1,
    output logic [IP_W-1:0]    exit_info2
);
    logic [IP_W-1:0] next_ip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_port   <= '0;
            lat_param  <= '0;
            next_ip    <= '0;
            rd_addr    <= '0;
            exit_hit   <= 1'b0;
            exit_code  <= '0;
            exit_info1 <= '0;
            exit_info2 <= '0;
        end else if (accept) begin
            lat_port   <= port;
            lat_param  <= param;
            next_ip    <= cur_ip + IP_W'(instr_len);
            rd_addr    <= bitmap_base + ADDR_W'(port >> 3);
            exit_hit   <= 1'b0;
            exit_code  <= '0;
            exit_info1 <= '0;
            exit_info2 <= '0;
        end else if (capture && win_hit) begin
            exit_hit   <= 1'b1;
            exit_code  <= CODE_IO;
            exit_info1 <= 64'(lat_param) | (64'(lat_port) << 16);
            exit_info2 <= next_ip;
        end
    end
endmodule

// File: rtl/iopm_checker_top.sv
module iopm_checker_top
    import iopm_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int PORT_W  = 16,
    parameter int PARAM_W = 32,
    parameter int IP_W    = 64,
    parameter int LEN_W   = 4,
    parameter int VEC_W   = 64,
    parameter int WIN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VEC_W-1:0]   icept_vec,
    input  logic [ADDR_W-1:0]  bitmap_base,
    input  logic [PORT_W-1:0]  port,
    input  logic [PARAM_W-1:0] param,
    input  logic [IP_W-1:0]    cur_ip,
    input  logic [LEN_W-1:0]   instr_len,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic [WIN_W-1:0]   rd_data,
    output logic               done,
    output logic               exit_hit,
    output logic [31:0]        exit_code,
    output logic [63:0]        exit_info1,
    output logic [IP_W-1:0]    exit_info2
);
    localparam int SIZE_LSB = 4;
    localparam int SIZE_W   = 3;
    localparam int OFS_W    = 3;

    logic               accept, capture, busy, win_hit;
    logic [PORT_W-1:0]  lat_port;
    logic [PARAM_W-1:0] lat_param;

    iopm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .icept_on (icept_vec[IO_BIT]),
        .rd_valid (rd_valid),
        .accept   (accept),
        .capture  (capture),
        .rd_req   (rd_req),
        .done     (done),
        .busy     (busy)
    );

    iopm_window_test #(.WIN_W(WIN_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)) u_win (
        .window  (rd_data),
        .size    (lat_param[SIZE_LSB +: SIZE_W]),
        .bit_ofs (lat_port[OFS_W-1:0]),
        .hit     (win_hit)
    );

    iopm_result #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PARAM_W(PARAM_W),
        .IP_W(IP_W), .LEN_W(LEN_W), .CODE_W(32), .CODE_IO(32'(EXIT_IO))
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture     (capture),
        .win_hit     (win_hit),
        .bitmap_base (bitmap_base),
        .port        (port),
        .param       (param),
        .cur_ip      (cur_ip),
        .instr_len   (instr_len),
        .lat_port    (lat_port),
        .lat_param   (lat_param),
        .rd_addr     (rd_addr),
        .exit_hit    (exit_hit),
        .exit_code   (exit_code),
        .exit_info1  (exit_info1),
        .exit_info2  (exit_info2)
    );
endmodule

// File: rtl/iopm_checker.sv
module iopm_checker
    import iopm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PORT_W = 16,
    parameter int VEC_W  = 64,
    parameter int IP_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [VEC_W-1:0]  icept_vec,
    input logic [ADDR_W-1:0] bitmap_base,
    input logic [PORT_W-1:0] port,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              exit_hit,
    input logic [31:0]       exit_code,
    input logic [63:0]       exit_info1,
    input logic [IP_W-1:0]   exit_info2
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r3_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && icept_vec[IO_BIT]) |=>
            (rd_req && rd_addr == $past(bitmap_base) + ADDR_W'($past(port) >> 3)));

    a_r2_skip_read: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !icept_vec[IO_BIT]) |=> (done && !rd_req && !exit_hit));

    a_r9_quiet_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !exit_hit) |-> (exit_info1 == '0 && exit_info2 == '0 && exit_code == '0));

    a_r7_code: assert property (@(posedge clk) disable iff (!rst_n)
        exit_hit |-> exit_code == 32'(EXIT_IO));
endmodule

bind iopm_checker_top iopm_checker #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .VEC_W(VEC_W), .IP_W(IP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .icept_vec   (icept_vec),
    .bitmap_base (bitmap_base),
    .port        (port),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .done        (done),
    .exit_hit    (exit_hit),
    .exit_code   (exit_code),
    .exit_info1  (exit_info1),
    .exit_info2  (exit_info2)
);

// File: tb/sim_iopm_checker_top.sv
module sim_iopm_checker_top;
    localparam int          LAT   = 3;
    localparam logic [63:0] BASE  = 64'h0000_0000_0010_0000;
    localparam int          MEM_N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] icept_vec = '0;
    logic [63:0] bitmap_base = BASE;
    logic [15:0] port = '0;
    logic [31:0] param = '0;
    logic [63:0] cur_ip = '0;
    logic [3:0]  instr_len = '0;
    logic        rd_req, rd_valid, done, exit_hit;
    logic [63:0] rd_addr, exit_info1, exit_info2;
    logic [15:0] rd_data;
    logic [31:0] exit_code;

    logic [7:0]  bmem [MEM_N];
    logic [LAT-1:0] vpipe;
    logic [63:0] apipe [LAT];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    iopm_checker_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .icept_vec(icept_vec),
        .bitmap_base(bitmap_base), .port(port), .param(param),
        .cur_ip(cur_ip), .instr_len(instr_len), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .exit_hit(exit_hit), .exit_code(exit_code),
        .exit_info1(exit_info1), .exit_info2(exit_info2)
    );

    // Bitmap memory model with fixed read latency
    always @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], rd_req};
        apipe[0] <= rd_addr;
        for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
    end

    int unsigned ridx;
    always_comb begin
        ridx     = 32'(apipe[LAT-1] - BASE);
        rd_valid = vpipe[LAT-1];
        if (ridx + 1 < MEM_N) rd_data = {bmem[ridx+1], bmem[ridx]};
        else                  rd_data = '0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_map();
        for (int i = 0; i < MEM_N; i++) bmem[i] = 8'h00;
    endtask

    // Run one check; returns observations
    task automatic run_access(input logic en, input logic [15:0] p, input logic [31:0] prm,
                              input logic [63:0] ip, input logic [3:0] len, input logic extra_start,
                              output int reqs, output logic [63:0] addr, output int cycles,
                              output int dones, output logic hit, output logic [31:0] code,
                              output logic [63:0] i1, output logic [63:0] i2);
        icept_vec = en ? (64'd1 << 27) : 64'd0;
        port = p; param = prm; cur_ip = ip; instr_len = len;
        start = 1'b1;
        reqs = 0; dones = 0; cycles = 0; addr = '0;
        hit = 1'b0; code = '0; i1 = '0; i2 = '0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            cycles++;
            if (rd_req) begin reqs++; addr = rd_addr; end
            if (done) begin
                dones++;
                hit = exit_hit; code = exit_code; i1 = exit_info1; i2 = exit_info2;
                break;
            end
            if (extra_start && k == 1) begin
                port = 16'hFFFF;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        if (done) dones++;
        @(negedge clk);
        if (done) dones++;
        if (rd_req) reqs++;
    endtask

    function automatic logic exp_hit(input logic [15:0] p, input logic [31:0] prm);
        int unsigned idx = 32'(p >> 3);
        logic [15:0] win = {bmem[idx+1], bmem[idx]};
        logic [15:0] m = ((16'd1 << prm[6:4]) - 16'd1) << p[2:0];
        return |(win & m);
    endfunction

    task automatic do_access(input string req, input logic en, input logic [15:0] p,
                             input logic [31:0] prm, input logic [63:0] ip,
                             input logic [3:0] len, input logic extra);
        int reqs, cyc, dn;
        logic [63:0] addr, i1, i2;
        logic hit, eh;
        logic [31:0] code;
        run_access(en, p, prm, ip, len, extra, reqs, addr, cyc, dn, hit, code, i1, i2);
        eh = en && exp_hit(p, prm);
        check({req, " hit"}, 64'(hit), 64'(eh));
        check({req, " R10 done count"}, 64'(dn), 64'd1);
        if (!en) begin
            check({req, " R2 latency"}, 64'(cyc), 64'd1);
            check({req, " R2 no read"}, 64'(reqs), 64'd0);
        end else begin
            check({req, " R3 one read"}, 64'(reqs), 64'd1);
            check({req, " R3 addr"}, addr, BASE + 64'(p >> 3));
        end
        if (eh) begin
            check({req, " R7 code"}, 64'(code), 64'h7B);
            check({req, " R7 info1"}, i1, 64'(prm) | (64'(p) << 16));
            check({req, " R8 info2"}, i2, ip + 64'(len));
        end else begin
            check({req, " R9 code"}, 64'(code), 64'd0);
            check({req, " R9 info1"}, i1, 64'd0);
            check({req, " R9 info2"}, i2, 64'd0);
        end
    endtask

    task automatic t_reset();
        check("R1 done", 64'(done), 64'd0);
        check("R1 rd_req", 64'(rd_req), 64'd0);
        check("R1 hit", 64'(exit_hit), 64'd0);
        check("R1 info1", exit_info1, 64'd0);
    endtask

    task automatic t_disabled();
        clear_map(); bmem[8] = 8'hFF;
        do_access("R2 disabled", 1'b0, 16'h0040, 32'h10, 64'h1000, 4'd2, 1'b0);
    endtask

    task automatic t_simple_hit();
        clear_map(); bmem[8] = 8'h04;
        do_access("R4 R5 simple hit", 1'b1, 16'h0042, 32'h0000_0010, 64'h2000, 4'd1, 1'b0);
    endtask

    task automatic t_miss();
        clear_map(); bmem[8] = 8'hE3;
        do_access("R5 R9 miss", 1'b1, 16'h0042, 32'h0000_0030, 64'h3000, 4'd2, 1'b0);
    endtask

    task automatic t_cross();
        clear_map(); bmem[8] = 8'h00; bmem[9] = 8'h01;
        do_access("R4 R5 cross byte", 1'b1, 16'h0047, 32'h0000_0020, 64'h4000, 4'd3, 1'b0);
    endtask

    task automatic t_size_zero();
        clear_map(); bmem[100] = 8'hFF; bmem[101] = 8'hFF;
        do_access("R6 size zero", 1'b1, 16'h0320, 32'h0000_0008, 64'h5000, 4'd1, 1'b0);
    endtask

    task automatic t_wide_run();
        clear_map(); bmem[501] = 8'h01;
        do_access("R5 wide run", 1'b1, 16'h0FAD, 32'h0000_0049, 64'hFFFF_0000_0000_FFF0, 4'd15, 1'b0);
    endtask

    task automatic t_busy_start();
        clear_map(); bmem[20] = 8'h80;
        do_access("R10 busy start", 1'b1, 16'h00A7, 32'h0000_0010, 64'h6000, 4'd2, 1'b1);
    endtask

    initial begin
        clear_map();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_simple_hit();
        t_miss();
        t_cross();
        t_size_zero();
        t_wide_run();
        t_busy_start();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule